// File: doc/BRIEF.md
# Programmable Address Translation Windows

This block maps a 40-bit CPU transaction address onto a destination code and a translated address. It holds a small bank of decode windows, five by default, which software programs. Each window has an enable, a 4-bit destination code, a 64 KB-aligned match base, a size mask and a 64 KB-aligned replacement base. A lookup port is evaluated combinationally against the registered window state. It reports whether any enabled window claims the address. When one does, it returns that window's destination and the address with its upper bits swapped for the replacement base.

Software programs a window through a single-cycle write port and reads it back on a combinational read port. To reconfigure a window safely, software first clears the enable. It then writes the match base, the replacement base and the size, and finally writes the destination code together with the enable. The decoder itself does not enforce this order.

Top module: `xlat_window_decoder`

## Requirements
- R1: Register access uses `cfg_win` to pick the window and `cfg_sel` to pick the register: 0 = control, 1 = match base, 2 = size mask, 3 = replacement base. The control register holds enable at bit 0 and the destination code at bits [7:4]. The other three registers occupy bits [23:0], and those bits correspond to address bits [39:16]. `cfg_rdata` shows the selected register combinationally, and unused bits read zero. A window index of 5 or more reads zero, and writes to it change nothing.
- R2: After reset every enable is clear and every base, size and replacement field is zero, so all lookups miss.
- R3: An address matches window i when address bits [39:16], with the bits set in the size mask removed, equal the match base with the same bits removed. A size field of v, written as ones from the LSB, gives a window of (v+1) × 64 KB.
- R4: A window whose enable bit is clear never produces a hit, whatever its other fields hold.
- R5: On a hit, `lk_raddr[15:0]` equals `lk_addr[15:0]`. `lk_raddr[39:16]` takes the replacement base where the size mask is 0 and the incoming address where it is 1.
- R6: When several enabled windows match, the lowest-numbered window supplies the destination and the translated address.
- R7: When no window matches, `lk_miss` is 1, `lk_hit` is 0, `lk_target` is 0 and `lk_raddr` equals `lk_addr`.
- R8: A register write takes effect at the next rising clock edge. A lookup in the same cycle as the write uses the values held before it.
- R9: The destination code is returned exactly as written, including the codes 7 and 8 and the unused code 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 3 | Window index for read and write |
| cfg_sel | input | 2 | Register select within the window |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| lk_addr | input | 40 | Address to translate |
| lk_hit | output | 1 | Some enabled window matched |
| lk_miss | output | 1 | No window matched |
| lk_target | output | 4 | Destination code of the winning window, 0 on miss |
| lk_raddr | output | 40 | Translated address |

## Verification
A register write and a lookup can happen in the same cycle. This matters most when software disables or moves a window while traffic is still aimed at it. The bench provokes this by clearing the enable of a window that claims the lookup address. It expects the hit to persist for that cycle and the following lookup to fall through to a lower-priority overlapping window. The reference model applies writes only after the clock edge, so every same-cycle pairing in the randomized phase is judged the same way.

// File: rtl/xlat_window_decoder.sv
module xlat_window_decoder #(
  parameter int NWIN = 5,
  parameter int AW   = 40,
  parameter int GRAN = 16,
  parameter int TW   = 4,
  parameter int DW   = 32,
  localparam int WSEL = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [WSEL-1:0] cfg_win,
  input  logic [1:0]      cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  input  logic [AW-1:0]   lk_addr,
  output logic            lk_hit,
  output logic            lk_miss,
  output logic [TW-1:0]   lk_target,
  output logic [AW-1:0]   lk_raddr
);
  localparam int IW = AW - GRAN;

  logic [NWIN-1:0] en_q;
  logic [TW-1:0]   tgt_q   [NWIN];
  logic [IW-1:0]   base_q  [NWIN];
  logic [IW-1:0]   size_q  [NWIN];
  logic [IW-1:0]   remap_q [NWIN];

  logic win_ok;
  assign win_ok = 32'(cfg_win) < NWIN;

  logic unused_hi;
  assign unused_hi = ^cfg_wdata[DW-1:IW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < NWIN; i++) begin
        tgt_q[i]   <= '0;
        base_q[i]  <= '0;
        size_q[i]  <= '0;
        remap_q[i] <= '0;
      end
    end else if (cfg_we && win_ok) begin
      case (cfg_sel)
        2'd0: begin
          en_q[cfg_win]  <= cfg_wdata[0];
          tgt_q[cfg_win] <= cfg_wdata[4 +: TW];
        end
        2'd1: base_q[cfg_win]  <= cfg_wdata[IW-1:0];
        2'd2: size_q[cfg_win]  <= cfg_wdata[IW-1:0];
        default: remap_q[cfg_win] <= cfg_wdata[IW-1:0];
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (win_ok) begin
      case (cfg_sel)
        2'd0: begin
          cfg_rdata[0]      = en_q[cfg_win];
          cfg_rdata[4 +: TW] = tgt_q[cfg_win];
        end
        2'd1: cfg_rdata[IW-1:0] = base_q[cfg_win];
        2'd2: cfg_rdata[IW-1:0] = size_q[cfg_win];
        default: cfg_rdata[IW-1:0] = remap_q[cfg_win];
      endcase
    end
  end

  wire [IW-1:0] page = lk_addr[AW-1:GRAN];
  logic [NWIN-1:0] match;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign match[g] = en_q[g] && (((page ^ base_q[g]) & ~size_q[g]) == '0);
  end

  int win_sel;
  always_comb begin
    win_sel = 0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (match[i]) win_sel = i;
  end

  assign lk_hit    = |match;
  assign lk_miss   = ~lk_hit;
  assign lk_target = lk_hit ? tgt_q[win_sel] : '0;
  assign lk_raddr  = lk_hit
    ? {(remap_q[win_sel] & ~size_q[win_sel]) | (page & size_q[win_sel]), lk_addr[GRAN-1:0]}
    : lk_addr;

  assert_hit_xor_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit != lk_miss);
  assert_miss_target_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_target == '0 && lk_raddr == lk_addr));
  assert_hit_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (|en_q));
  assert_offset_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_raddr[GRAN-1:0] == lk_addr[GRAN-1:0]));
  assert_base_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && win_ok && cfg_sel == 2'd1) |=> (base_q[$past(cfg_win)] == $past(cfg_wdata[IW-1:0])));
endmodule

// File: tb/xlat_window_decoder_bench.sv
module xlat_window_decoder_bench;
  localparam int CLK_NS = 10;
  localparam int NW = 5;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_win = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [39:0] lk_addr = 0;
  logic        lk_hit, lk_miss;
  logic [3:0]  lk_target;
  logic [39:0] lk_raddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  xlat_window_decoder u_xlat_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_target(lk_target), .lk_raddr(lk_raddr));

  bit          m_en    [NW];
  logic [3:0]  m_tgt   [NW];
  logic [23:0] m_base  [NW];
  logic [23:0] m_size  [NW];
  logic [23:0] m_remap [NW];

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input int win, input int sel, input logic [31:0] wd,
                      input logic [39:0] la, input string tag);
    bit e_hit;
    logic [3:0] e_tgt;
    logic [39:0] e_ra;
    logic [31:0] e_rd;
    @(negedge clk);
    cfg_we = we; cfg_win = 3'(win); cfg_sel = 2'(sel); cfg_wdata = wd; lk_addr = la;
    #1;
    e_hit = 0; e_tgt = 0; e_ra = la;
    for (int i = 0; i < NW; i++)
      if (!e_hit && m_en[i] && ((la[39:16] & ~m_size[i]) == (m_base[i] & ~m_size[i]))) begin
        e_hit = 1;
        e_tgt = m_tgt[i];
        e_ra = {(m_remap[i] & ~m_size[i]) | (la[39:16] & m_size[i]), la[15:0]};
      end
    e_rd = 0;
    if (win < NW)
      case (sel)
        0: e_rd = {24'd0, m_tgt[win], 3'd0, m_en[win]};
        1: e_rd = {8'd0, m_base[win]};
        2: e_rd = {8'd0, m_size[win]};
        default: e_rd = {8'd0, m_remap[win]};
      endcase
    check("R1", "rdata", 64'(cfg_rdata), 64'(e_rd));
    check(tag, "hit", 64'(lk_hit), 64'(e_hit));
    check("R7", "miss", 64'(lk_miss), 64'(!e_hit));
    check(tag, "target", 64'(lk_target), 64'(e_tgt));
    check(tag, "raddr", 64'(lk_raddr), 64'(e_ra));
    @(posedge clk);
    #1;
    if (we && win < NW)
      case (sel)
        0: begin m_en[win] = wd[0]; m_tgt[win] = wd[7:4]; end
        1: m_base[win] = wd[23:0];
        2: m_size[win] = wd[23:0];
        default: m_remap[win] = wd[23:0];
      endcase
  endtask

  task automatic prog(input int win, input logic [23:0] b, input logic [23:0] s,
                      input logic [23:0] r, input logic [3:0] t, input logic [39:0] probe);
    step(1, win, 0, 32'h0, probe, "R8");
    step(1, win, 1, {8'd0, b}, probe, "R8");
    step(1, win, 3, {8'd0, r}, probe, "R8");
    step(1, win, 2, {8'd0, s}, probe, "R8");
    step(1, win, 0, {24'd0, t, 4'h1}, probe, "R8");
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_en[i] = 0; m_tgt[i] = 0; m_base[i] = 0; m_size[i] = 0; m_remap[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int w = 0; w < 8; w++)
      for (int s = 0; s < 4; s++)
        step(0, w, s, 32'h0, 40'h00_0000_0000 + 40'(w), "R2");
    step(0, 0, 0, 0, 40'h00_E000_1234, "R2");

    prog(1, 24'h00E000, 24'h0007FF, 24'h00E000, 4'd5, 40'h00_E012_3456);
    step(0, 1, 2, 0, 40'h00_E7FF_FFFF, "R3");
    step(0, 1, 1, 0, 40'h00_E800_0000, "R3");
    step(0, 1, 1, 0, 40'h00_DFFF_FFFF, "R3");
    prog(3, 24'h00F000, 24'h000001, 24'h001FFF, 4'd7, 40'h00_F001_ABCD);
    step(0, 3, 3, 0, 40'h00_F001_ABCD, "R5");
    step(0, 3, 3, 0, 40'h00_F000_0010, "R5");
    step(0, 3, 0, 0, 40'h00_F002_0000, "R3");
    prog(2, 24'h00E000, 24'h000FFF, 24'h123000, 4'd2, 40'h00_E100_0000);
    step(0, 2, 0, 0, 40'h00_E100_0000, "R6");
    step(0, 2, 0, 0, 40'h00_EC00_0042, "R5");
    prog(4, 24'hFE0000, 24'h000000, 24'hAB0000, 4'd8, 40'hFE_0000_9999);
    step(0, 4, 0, 0, 40'hFE_0000_9999, "R9");
    prog(0, 24'h000000, 24'h007FFF, 24'h000000, 4'd6, 40'h00_1234_5678);
    step(0, 0, 0, 0, 40'h00_7FFF_FFFF, "R9");
    step(1, 1, 0, 32'h0000_0050, 40'h00_E100_0000, "R8");
    step(0, 1, 0, 0, 40'h00_E100_0000, "R4");
    step(1, 1, 2, 32'h00FF_FFFF, 40'h00_E100_0000, "R4");
    step(0, 1, 2, 0, 40'h55_5555_5555, "R4");
    step(1, 6, 1, 32'h00AB_CDEF, 40'h00_E100_0000, "R1");
    step(0, 6, 1, 0, 40'h00_E100_0000, "R1");
    step(1, 5, 0, 32'h0000_00F1, 40'hAB_CDEF_0123, "R1");
    step(0, 5, 0, 0, 40'hAB_CDEF_0123, "R1");

    for (int n = 0; n < 400; n++) begin
      int w = $urandom % 6;
      int s = $urandom % 4;
      int k = $urandom % 25;
      logic [31:0] d = $urandom;
      logic [39:0] a = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      if (s == 2) d = {8'd0, 24'((64'd1 << k) - 1)};
      if (n % 2 == 0) a[39:16] = m_base[$urandom % NW] ^ 24'($urandom % 4);
      step(($urandom % 3) == 0, w, s, d, a, "R3");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule